// File: doc/BRIEF.md
# Switch-Selected Speed Display Driver

This block drives a four-digit, time-multiplexed seven-segment display that reads out a motor speed in RPM. Two 7-bit speed values arrive in units of ten RPM: the commanded speed and the measured shaft speed. A toggle switch picks which of the two is shown. Only three digit positions are lit. The rightmost lit digit is always a fixed `0`, so a value of 86 reads as `860`. The fourth position stays dark.

The block has two independent timing paths. A fast scanner moves through the three lit digits, roughly one millisecond per digit, so the readout looks steady. A slow timer, roughly one second by default, decides when a new value is captured into a latch, so the number does not flicker while the motor speed wanders. Moving the switch reloads the latch at once and restarts the slow timer.

The captured value goes through a shift-and-add-3 binary-to-decimal converter. Values above 99 are clamped to 99. Leading zeros are blanked, except for the fixed final zero. The segment and digit-enable outputs are active-low and come straight from flip-flops.

Top module: `spd_disp_top`

## Requirements
- R1: While `rst` is high, every clock edge drives all four `dig_n` bits high and all seven `seg_n` bits high.
- R2: Outside reset, at most one `dig_n` bit is low at a time. The lit digits are enabled in the order digit 0, digit 1, digit 2, then back to digit 0. Each one stays enabled for `SCAN_DIV` clock cycles. Digit k is enabled when `dig_n` equals the 4-bit value with only bit k cleared.
- R3: `dig_n[3]` is always high, so the fourth digit never lights.
- R4: `seg_n` is active-low, with bit 0 = segment a up to bit 6 = segment g. The lit-segment sets for the decimals 0 to 9 are the usual ones: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg.
- R5: Digit 0 always shows the decimal 0, so `seg_n` is 7'h40 whenever `dig_n` is 4'b1110.
- R6: Digit 2 shows the tens and digit 1 shows the units of the latched value. Any latched value above 99 is shown as 99.
- R7: A blank digit has `seg_n` all high. Digit 2 is blank when the shown tens is 0. Digit 1 is blank when the shown value is 0.
- R8: After a two-flop synchroniser, `show_meas` low selects `cmd_rpm10` and high selects `meas_rpm10`. The unselected input has no effect on the display.
- R9: Apart from the reloads in R10 and R11, the latch captures the selected input only once every `TICK_DIV` clock cycles. Changes of the inputs between captures do not change the display.
- R10: A change of the synchronised switch reloads the latch within the next clock and restarts the `TICK_DIV` count.
- R11: On the first clock after reset is released, the latch loads the selected input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rpm10 | input | 7 | Commanded speed in units of 10 RPM |
| meas_rpm10 | input | 7 | Measured speed in units of 10 RPM |
| show_meas | input | 1 | Source switch: 0 command, 1 measured (asynchronous) |
| seg_n | output | 7 | Segment drives a..g, bit 0 = a, active low |
| dig_n | output | 4 | Digit enables, bit 0 = rightmost, active low |

## Verification
The bench reads the three lit digits back from the scanned outputs for a set of values. Together they use every decimal glyph and cover a zero value, a single-digit value, the largest in-range value and two values past 99. This separates wrong segment tables, swapped tens and units, missing blanking and missing clamping.

The latch timing is tested by moving the switch and then changing the newly selected input right away. The display must keep the old number for a fraction of the update period and show the new one after a full period. A buggy latch that follows its input, or a slow timer that a switch change fails to restart, would show the new number too early.

A final pattern changes only the unselected input, which must leave the readout unchanged.

// File: rtl/spd_disp_pkg.sv
package spd_disp_pkg;

  localparam int SEG_W = 7;

  typedef logic [3:0] bcd_t;

  // Active-high segment set, bit0 = a ... bit6 = g.
  function automatic logic [SEG_W-1:0] glyph(input bcd_t d);
    logic [SEG_W-1:0] g;
    case (d)
      4'd0:    g = 7'h3F;
      4'd1:    g = 7'h06;
      4'd2:    g = 7'h5B;
      4'd3:    g = 7'h4F;
      4'd4:    g = 7'h66;
      4'd5:    g = 7'h6D;
      4'd6:    g = 7'h7D;
      4'd7:    g = 7'h07;
      4'd8:    g = 7'h7F;
      4'd9:    g = 7'h6F;
      default: g = 7'h00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/spd_disp_sync.sv
module spd_disp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/spd_disp_tick.sv
module spd_disp_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spd_disp_bcd.sv
module spd_disp_bcd #(
  parameter int IN_W = 7,
  parameter int DIG  = 3
) (
  input  logic [IN_W-1:0]  bin,
  output logic [DIG*4-1:0] bcd
);

  localparam int ACC_W = IN_W + DIG * 4;

  logic [ACC_W-1:0] acc;

  // Shift-and-add-3: adjust every decimal nibble before each shift.
  always_comb begin
    acc = '0;
    acc[IN_W-1:0] = bin;
    for (int i = 0; i < IN_W; i++) begin
      for (int d = 0; d < DIG; d++) begin
        if (acc[IN_W + 4*d +: 4] >= 4'd5)
          acc[IN_W + 4*d +: 4] = acc[IN_W + 4*d +: 4] + 4'd3;
      end
      acc = acc << 1;
    end
    bcd = acc[IN_W +: DIG*4];
  end

endmodule

// File: rtl/spd_disp_top.sv
module spd_disp_top
  import spd_disp_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCAN_HZ     = 1_000,
  parameter int UPD_HZ      = 1,
  parameter int SCAN_DIV    = CLK_HZ / SCAN_HZ,
  parameter int TICK_DIV    = CLK_HZ / UPD_HZ,
  parameter int VAL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] cmd_rpm10,
  input  logic [VAL_W-1:0] meas_rpm10,
  input  logic             show_meas,
  output logic [6:0]       seg_n,
  output logic [3:0]       dig_n
);

  localparam int NUM_DIG = 4;
  localparam int LIT_DIG = 3;
  localparam int IDX_W   = $clog2(LIT_DIG);
  localparam int BCD_DIG = 3;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LIT_DIG - 1);

  // ---------------- source select and value latch ----------------
  logic             sel_s, sel_prev, sel_chg;
  logic             load_pend, slow_tick, load;
  logic [VAL_W-1:0] val_q;

  spd_disp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (show_meas),
    .d_sync  (sel_s)
  );

  assign sel_chg = sel_s ^ sel_prev;

  spd_disp_tick #(.DIV(TICK_DIV)) u_slow (
    .clk  (clk),
    .rst  (rst),
    .clr  (sel_chg),
    .tick (slow_tick)
  );

  assign load = slow_tick | sel_chg | load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev  <= 1'b0;
      load_pend <= 1'b1;
      val_q     <= '0;
    end else begin
      sel_prev  <= sel_s;
      load_pend <= 1'b0;
      if (load) val_q <= sel_s ? meas_rpm10 : cmd_rpm10;
    end
  end

  // ---------------- decimal conversion with clamp ----------------
  logic [BCD_DIG*4-1:0] bcd;
  logic                 over;
  bcd_t                 tens_d, units_d;
  logic                 val_zero;

  spd_disp_bcd #(.IN_W(VAL_W), .DIG(BCD_DIG)) u_bcd (
    .bin (val_q),
    .bcd (bcd)
  );

  assign over     = |bcd[BCD_DIG*4-1:8];
  assign tens_d   = over ? 4'd9 : bcd[7:4];
  assign units_d  = over ? 4'd9 : bcd[3:0];
  assign val_zero = (tens_d == 4'd0) && (units_d == 4'd0);

  // ---------------- digit scanner ----------------
  logic             scan_ce;
  logic [IDX_W-1:0] scan_idx;

  spd_disp_tick #(.DIV(SCAN_DIV)) u_scan (
    .clk  (clk),
    .rst  (rst),
    .clr  (1'b0),
    .tick (scan_ce)
  );

  always_ff @(posedge clk) begin
    if (rst)          scan_idx <= '0;
    else if (scan_ce) scan_idx <= (scan_idx == IDX_LAST) ? '0 : scan_idx + 1'b1;
  end

  logic [SEG_W-1:0]   pat_hi;
  logic [NUM_DIG-1:0] dig_next;

  always_comb begin
    case (scan_idx)
      IDX_W'(0): pat_hi = glyph(4'd0);
      IDX_W'(1): pat_hi = val_zero ? '0 : glyph(units_d);
      IDX_W'(2): pat_hi = (tens_d == 4'd0) ? '0 : glyph(tens_d);
      default:   pat_hi = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    if (g < LIT_DIG) begin : g_lit
      assign dig_next[g] = (scan_idx != IDX_W'(g));
    end else begin : g_dark
      assign dig_next[g] = 1'b1;
    end
  end

  // ---------------- registered active-low outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n <= '1;
      dig_n <= '1;
    end else begin
      seg_n <= ~pat_hi;
      dig_n <= dig_next;
    end
  end

endmodule

// File: rtl/spd_disp_chk.sv
module spd_disp_chk #(
  parameter int VAL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [6:0]       seg_n,
  input logic [3:0]       dig_n,
  input logic             slow_tick,
  input logic             sel_chg,
  input logic             load_pend,
  input logic [VAL_W-1:0] val_q
);

  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> (dig_n == 4'hF && seg_n == 7'h7F));

  p_one_digit_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_n));

  p_fourth_dark_r3: assert property (@(posedge clk) disable iff (rst)
    dig_n[3]);

  p_fixed_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (dig_n == 4'b1110) |-> (seg_n == 7'h40));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!slow_tick && !sel_chg && !load_pend) |=> $stable(val_q));

endmodule

bind spd_disp_top spd_disp_chk #(.VAL_W(VAL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .seg_n     (seg_n),
  .dig_n     (dig_n),
  .slow_tick (slow_tick),
  .sel_chg   (sel_chg),
  .load_pend (load_pend),
  .val_q     (val_q)
);

// File: tb/spd_disp_top_tb.sv
module spd_disp_top_tb;

  localparam int SD = 4;
  localparam int TD = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] cmd_rpm10 = '0;
  logic [6:0] meas_rpm10 = '0;
  logic       show_meas = 1'b0;
  logic [6:0] seg_n;
  logic [3:0] dig_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spd_disp_top #(.SCAN_DIV(SD), .TICK_DIV(TD)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .cmd_rpm10  (cmd_rpm10),
    .meas_rpm10 (meas_rpm10),
    .show_meas  (show_meas),
    .seg_n      (seg_n),
    .dig_n      (dig_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Expected active-low pattern; d < 0 means blank.
  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] on;
    case (d)
      0: on = 7'b0111111;  1: on = 7'b0000110;  2: on = 7'b1011011;
      3: on = 7'b1001111;  4: on = 7'b1100110;  5: on = 7'b1101101;
      6: on = 7'b1111101;  7: on = 7'b0000111;  8: on = 7'b1111111;
      9: on = 7'b1101111;  default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grab_digit(input int k, output logic [6:0] s);
    logic [3:0] pat;
    int n;
    pat = ~(4'b0001 << k);
    n = 0;
    @(negedge clk);
    while (dig_n != pat && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (n >= 100) check(0, "R2", "digit never enabled", k, k);
    s = seg_n;
  endtask

  task automatic expect_val(input int v, input string req);
    logic [6:0] s0, s1, s2;
    int sv;
    sv = (v > 99) ? 99 : v;
    grab_digit(0, s0);
    grab_digit(1, s1);
    grab_digit(2, s2);
    check(s0 == exp_seg(0), req, "digit0", s0, exp_seg(0));
    check(s1 == exp_seg(sv == 0 ? -1 : sv % 10), req, "digit1 units", s1,
          exp_seg(sv == 0 ? -1 : sv % 10));
    check(s2 == exp_seg(sv / 10 == 0 ? -1 : sv / 10), req, "digit2 tens", s2,
          exp_seg(sv / 10 == 0 ? -1 : sv / 10));
  endtask

  task automatic t_reset;
    cycles(3);
    check(dig_n == 4'hF, "R1", "dig_n in reset", dig_n, 4'hF);
    check(seg_n == 7'h7F, "R1", "seg_n in reset", seg_n, 7'h7F);
  endtask

  task automatic t_first_load;
    cmd_rpm10 = 7'd42;
    meas_rpm10 = 7'd5;
    rst = 1'b0;
    expect_val(42, "R11 first load of command 42");
  endtask

  task automatic t_scan;
    logic [3:0] prev, seq [3];
    int n;
    while (dig_n != 4'b1110) @(negedge clk);
    prev = dig_n;
    for (int i = 0; i < 3; i++) begin
      n = 0;
      while (dig_n == prev && n < 50) begin
        @(negedge clk);
        n++;
      end
      check(n == SD, "R2", "dwell cycles", n, SD);
      seq[i] = dig_n;
      check(dig_n[3], "R3", "fourth digit dark", dig_n, 4'b1000);
      prev = dig_n;
    end
    check(seq[0] == 4'b1101, "R2", "order step 1", seq[0], 4'b1101);
    check(seq[1] == 4'b1011, "R2", "order step 2", seq[1], 4'b1011);
    check(seq[2] == 4'b1110, "R2", "order step 3", seq[2], 4'b1110);
  endtask

  task automatic t_select;
    meas_rpm10 = 7'd73;
    show_meas = 1'b1;
    cycles(6);
    expect_val(73, "R10 switch reload to measured 73 (R8)");
  endtask

  task automatic t_hold;
    meas_rpm10 = 7'd15;
    cycles(TD / 4);
    expect_val(73, "R9 hold before tick");
    cycles(TD);
    expect_val(15, "R9 capture at tick");
  endtask

  task automatic t_clamp;
    cmd_rpm10 = 7'd127;
    show_meas = 1'b0;
    cycles(6);
    expect_val(127, "R6 clamp 127 (R10 reload to command)");
    cmd_rpm10 = 7'd100;
    cycles(TD + 20);
    expect_val(100, "R6 clamp 100");
  endtask

  task automatic t_digits;
    cmd_rpm10 = 7'd0;
    cycles(TD + 20);
    expect_val(0, "R7 zero value blanking");
    cmd_rpm10 = 7'd7;
    cycles(TD + 20);
    expect_val(7, "R7 single digit blanking");
    cmd_rpm10 = 7'd86;
    cycles(TD + 20);
    expect_val(86, "R4 glyphs 8 and 6");
  endtask

  task automatic t_unselected;
    meas_rpm10 = 7'd11;
    cycles(TD + 20);
    expect_val(86, "R8 unselected input ignored");
  endtask

  initial begin
    t_reset();
    t_first_load();
    t_scan();
    t_select();
    t_hold();
    t_clamp();
    t_digits();
    t_unselected();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule